// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a group (multicast) destination MAC address is wanted by the receiver. The address enters one byte per accepted cycle. The first byte on the wire comes first. The block folds the six bytes into an Ethernet CRC-32 and turns the result into an 8-bit index. It then looks that index up in a 256-entry bit table. A one-cycle verdict pulse follows at a fixed latency. The verdict is hit when the addressed table bit is set, and miss otherwise.

The table lives in eight 32-bit words. Software, or a neighbouring block, writes these words through a plain select/write-enable port. The same port returns the selected word combinationally. Addresses whose group bit is clear are never looked up; they always report miss. The unicast match logic, frame parsing and the rest of the MAC sit elsewhere.

Top module: `mhf_filter`

## Requirements
- R1: After a synchronous active-low reset, all eight table words read as zero and `match_valid` is low, so every address misses until a bit is written.
- R2: The index is computed in four steps:
  - Start a CRC-32 from all ones, using the reflected polynomial 0xEDB88320.
  - Shift the address bytes in first byte first, each byte least significant bit first.
  - Apply no final inversion.
  - Bit-reverse the 32-bit remainder; its upper 8 bits are the index.
- R3: Index bits [7:3] select table word 0..7. Index bits [4:0] = n select bit position 31−n of that word, so entry 0 is bit 31 of word 0 and entry 255 is bit 0 of word 7. `match_hit` is 1 exactly when that bit is 1.
- R4: When bit 0 of the first address byte (the group bit) is 0, the verdict pulse still appears, with `match_hit` = 0, whatever the table holds.
- R5: `addr_valid` marks an accepted byte, and idle cycles between the bytes of one address are allowed. `match_valid` is high in the cycle that follows the second rising edge after the edge that accepts the sixth byte.
- R6: A write with `tbl_we` high replaces the word chosen by `tbl_sel` with `tbl_wdata` at that clock edge. `tbl_rdata` shows the word chosen by `tbl_sel` without a clock.
- R7: A table write on the same edge as a lookup is not seen by that lookup; the lookup uses the old contents. The next lookup of the same entry sees the new value.
- R8: `match_valid` is a single-cycle pulse, one per six accepted bytes. `match_hit` is never high while `match_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_valid | input | 1 | Address byte on `addr_byte` is accepted this cycle |
| addr_byte | input | 8 | Destination address byte, first byte on the wire first |
| tbl_we | input | 1 | Write strobe for the table word |
| tbl_sel | input | 3 | Table word select, 0..7 |
| tbl_wdata | input | 32 | Data for a table word write |
| tbl_rdata | output | 32 | Contents of the selected table word |
| match_valid | output | 1 | Verdict pulse for the last complete address |
| match_hit | output | 1 | Verdict: 1 = accepted by the table |

## Verification
A lookup of the table and a write to the very word it reads can fall on the same clock edge. The bench provokes this by issuing a word write immediately after the sixth byte. That timing makes the write land on the edge where the lookup samples the table.

The scoreboard expects the verdict from the shadow table as it stood before the write (R7). A second send of the same address must then reflect the new word. The bench judges each verdict by its value and by the cycle in which it arrives.

// File: rtl/mhf_pkg.sv
// Package: constants and the CRC step shared by the hash filter modules.
// Assumes the reflected (LSB-first) form of the Ethernet CRC-32.
package mhf_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

    // Advance a reflected CRC-32 remainder by one byte, LSB first.
    function automatic logic [31:0] crc_step_byte(input logic [31:0] rem_in,
                                                  input logic [7:0]  data);
        logic [31:0] rem;
        logic        fb;
        rem = rem_in;
        for (int i = 0; i < 8; i++) begin
            fb  = rem[0] ^ data[i];
            rem = rem >> 1;
            if (fb) rem = rem ^ CRC_POLY_REFL;
        end
        return rem;
    endfunction

endpackage

// File: rtl/mhf_crc_accum.sv
// Module: accumulates the CRC over one destination address.
// Counts accepted bytes and restarts the remainder from the seed on each
// first byte. It captures the group bit from that first byte and pulses
// done_q in the cycle after the last byte is taken.
// Assumes bytes of one address are never interleaved with another.
module mhf_crc_accum
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic [31:0] crc_q,
    output logic        grp_q,
    output logic        done_q
);

    localparam int CNT_W = $clog2(ADDR_BYTES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      rem_base;

    // Pick the starting remainder: the seed on the first byte, else the running value.
    always_comb begin
        rem_base = (cnt_q == '0) ? CRC_SEED : crc_q;
    end

    // Byte counter, remainder, group bit and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            crc_q  <= CRC_SEED;
            grp_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (in_valid) begin
                crc_q <= crc_step_byte(rem_base, in_byte);
                if (cnt_q == '0) grp_q <= in_byte[0];
                if (cnt_q == LAST_CNT) begin
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R5: the byte counter never leaves its range.
    p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_CNT);

    // R8: completion is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/mhf_hash_table.sv
// Module: the group hash table, held as NUM_WORDS words of WORD_W bits.
// Writes land on the clock edge; reads and the lookup bit are combinational.
// Bit n of a word's index field sits at position WORD_W-1-n (MSB-first).
module mhf_hash_table #(
    parameter int INDEX_W = 8,
    parameter int WORD_W  = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [INDEX_W-$clog2(WORD_W)-1:0]      sel,
    input  logic [WORD_W-1:0]                      wdata,
    output logic [WORD_W-1:0]                      rdata,
    input  logic [INDEX_W-1:0]                     look_idx,
    output logic                                   look_bit
);

    localparam int BIT_W     = $clog2(WORD_W);
    localparam int SEL_W     = INDEX_W - BIT_W;
    localparam int NUM_WORDS = 2 ** SEL_W;
    localparam logic [BIT_W-1:0] TOP_POS = BIT_W'(WORD_W - 1);

    logic [WORD_W-1:0] words_q [NUM_WORDS];
    logic [SEL_W-1:0]  look_word;
    logic [BIT_W-1:0]  look_pos;

    // Table storage: clear on reset, replace one word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WORDS; w++) words_q[w] <= '0;
        end else if (we) begin
            words_q[sel] <= wdata;
        end
    end

    // Read port and lookup decode (MSB-first bit numbering).
    always_comb begin
        rdata     = words_q[sel];
        look_word = look_idx[INDEX_W-1:BIT_W];
        look_pos  = TOP_POS - look_idx[BIT_W-1:0];
        look_bit  = words_q[look_word][look_pos];
    end

    // R1: every word is zero after a reset edge.
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_rst_chk
        p_reset_clear_r1: assert property (@(posedge clk)
            !rst_n |=> (words_q[g] == '0));
    end

    // R6: a write is visible in the selected word on the next cycle.
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (words_q[$past(sel)] == $past(wdata)));

endmodule

// File: rtl/mhf_filter.sv
// Module: multicast hash address filter top.
// It feeds the address bytes into the CRC accumulator. The bit-reversed
// remainder is registered, the hash table is looked up one cycle later,
// and a one-cycle verdict is issued. Latency from the edge that takes the
// last byte is two edges.
module mhf_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int INDEX_W    = 8,
    parameter int WORD_W     = 32
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  addr_valid,
    input  logic [7:0]                            addr_byte,
    input  logic                                  tbl_we,
    input  logic [INDEX_W-$clog2(WORD_W)-1:0]     tbl_sel,
    input  logic [WORD_W-1:0]                     tbl_wdata,
    output logic [WORD_W-1:0]                     tbl_rdata,
    output logic                                  match_valid,
    output logic                                  match_hit
);

    logic [31:0]        crc_q;
    logic               grp_q;
    logic               done_q;
    logic [INDEX_W-1:0] idx_c;
    logic [INDEX_W-1:0] s1_idx;
    logic               s1_valid;
    logic               s1_grp;
    logic               look_bit;

    mhf_crc_accum #(.ADDR_BYTES(ADDR_BYTES)) i_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(addr_valid),
        .in_byte (addr_byte),
        .crc_q   (crc_q),
        .grp_q   (grp_q),
        .done_q  (done_q)
    );

    // Index = top bits of the bit-reversed remainder = low remainder bits reversed.
    always_comb begin
        for (int i = 0; i < INDEX_W; i++) idx_c[INDEX_W-1-i] = crc_q[i];
    end

    // Stage 1: hold index, group bit and valid for the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_grp   <= 1'b0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= done_q;
            if (done_q) begin
                s1_grp <= grp_q;
                s1_idx <= idx_c;
            end
        end
    end

    mhf_hash_table #(.INDEX_W(INDEX_W), .WORD_W(WORD_W)) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .sel     (tbl_sel),
        .wdata   (tbl_wdata),
        .rdata   (tbl_rdata),
        .look_idx(s1_idx),
        .look_bit(look_bit)
    );

    // Stage 2: register the verdict; group bit gates the table bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_valid <= 1'b0;
            match_hit   <= 1'b0;
        end else begin
            match_valid <= s1_valid;
            match_hit   <= s1_valid && s1_grp && look_bit;
        end
    end

    // R5: a completed address yields a verdict two edges later.
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> ##1 match_valid);

    // R5: every verdict traces back to a completed address.
    p_valid_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |-> $past(done_q, 2));

    // R4: an individual (non-group) address never hits.
    p_nongroup_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_grp) |=> !match_hit);

    // R8: single-cycle verdict, and no hit without it.
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_valid |=> !match_valid);

    p_hit_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |-> match_valid);

endmodule

// File: tb/test_mhf_filter.sv
// Scoreboard bench for mhf_filter: the driver pushes expected verdicts,
// the monitor pops and compares value and arrival cycle.
module test_mhf_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_sel = '0;
    logic [31:0] tbl_wdata = '0;
    logic [31:0] tbl_rdata;
    logic        match_valid;
    logic        match_hit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [31:0] shadow [8];
    bit          exp_hit [$];
    int          exp_cyc [$];
    string       exp_tag [$];

    mhf_filter i_mhf_filter (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_byte(addr_byte),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_wdata(tbl_wdata),
        .tbl_rdata(tbl_rdata), .match_valid(match_valid), .match_hit(match_hit)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference index, MSB-first register form (equals the reversed reflected CRC).
    function automatic logic [7:0] ref_index(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  b;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int j = 0; j < 6; j++) begin
            b = a[47-8*j -: 8];
            for (int i = 0; i < 8; i++) begin
                fb = c[31] ^ b[i];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c[31:24];
    endfunction

    function automatic bit ref_hit(input logic [47:0] a);
        logic [7:0] ix;
        ix = ref_index(a);
        return a[40] && shadow[ix[7:5]][31 - ix[4:0]];
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = 3'(sel); tbl_wdata = data;
        @(negedge clk);
        tbl_we = 1'b0;
        shadow[sel] = data;
    endtask

    task automatic rd_check(input int sel, input string tag);
        @(negedge clk);
        tbl_sel = 3'(sel);
        #1;
        check(tbl_rdata == shadow[sel], tag, tbl_rdata, shadow[sel]);
    endtask

    // Drive six bytes; gap idle cycles follow each byte except the last.
    task automatic send(input logic [47:0] a, input int gap, input string tag);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            addr_valid = 1'b1;
            addr_byte  = a[47-8*j -: 8];
            if (j == 5) begin
                exp_hit.push_back(ref_hit(a));
                exp_cyc.push_back(cyc + 3);
                exp_tag.push_back(tag);
            end else begin
                for (int k = 0; k < gap; k++) begin
                    @(negedge clk);
                    addr_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop expected verdict, compare value and arrival cycle.
    always @(negedge clk) begin
        if (rst_n && match_valid) begin
            if (exp_hit.size() == 0) begin
                check(1'b0, "R8 unexpected verdict", 1, 0);
            end else begin
                bit    eh;
                int    ec;
                string et;
                eh = exp_hit.pop_front();
                ec = exp_cyc.pop_front();
                et = exp_tag.pop_front();
                check(match_hit == eh, et, match_hit, eh);
                check(cyc == ec, "R5 latency", cyc, ec);
            end
        end else if (rst_n && match_hit) begin
            check(1'b0, "R8 hit without valid", 1, 0);
        end
    end

    initial begin
        logic [47:0] a_hit, a_other, a_ind, a0, a255;
        logic [7:0]  ix;
        bit          f0, f255;
        for (int w = 0; w < 8; w++) shadow[w] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        check(match_valid == 1'b0, "R1 valid after reset", match_valid, 0);
        for (int w = 0; w < 8; w++) rd_check(w, "R1 word zero after reset");

        a_hit = 48'h01005E0A1B2C;
        // R1: empty table misses
        send(a_hit, 0, "R1 empty table miss");
        idle(4);

        // R2/R3: set exactly the entry of a_hit, MSB-first position
        ix = ref_index(a_hit);
        wr(ix[7:5], 32'h1 << (31 - ix[4:0]));
        rd_check(ix[7:5], "R6 readback after write");
        send(a_hit, 0, "R3 single entry hit");
        idle(4);

        // R3: all bits but the entry's own -> miss
        wr(ix[7:5], ~(32'h1 << (31 - ix[4:0])));
        send(a_hit, 0, "R3 complement word miss");
        idle(4);
        wr(ix[7:5], 32'hFFFF_FFFF);

        // R4: individual address with its entry set -> miss
        a_ind = 48'h00112233_4455;
        ix = ref_index(a_ind);
        wr(ix[7:5], shadow[ix[7:5]] | (32'h1 << (31 - ix[4:0])));
        send(a_ind, 0, "R4 individual address miss");
        idle(4);

        // R5: gaps between bytes
        send(a_hit, 2, "R5 gapped bytes hit");
        idle(4);

        // R3 boundary: entries 0 and 255
        f0 = 0; f255 = 0; a0 = '0; a255 = '0;
        for (int v = 0; v < 65536 && !(f0 && f255); v++) begin
            logic [47:0] t;
            t = {32'h01005E00, 16'(v)};
            if (!f0 && ref_index(t) == 8'd0) begin a0 = t; f0 = 1; end
            if (!f255 && ref_index(t) == 8'd255) begin a255 = t; f255 = 1; end
        end
        check(f0 && f255, "R3 boundary addresses found", {f0, f255}, 3);
        for (int w = 0; w < 8; w++) wr(w, 32'h0);
        wr(0, 32'h8000_0000);
        wr(7, 32'h0000_0001);
        rd_check(7, "R6 readback word 7");
        send(a0, 0, "R3 entry 0 hit");
        send(a255, 0, "R3 entry 255 hit");
        idle(4);
        wr(0, 32'h0000_0001);
        wr(7, 32'h8000_0000);
        send(a0, 0, "R3 entry 0 wrong end miss");
        send(a255, 0, "R3 entry 255 wrong end miss");
        idle(4);

        // R7: write lands on the lookup edge -> old value used
        wr(0, 32'h8000_0000);
        send(a0, 0, "R7 collision uses old word");
        wr(0, 32'h0000_0000);
        idle(4);
        send(a0, 0, "R7 later lookup sees new word");
        idle(4);

        // R8: back-to-back addresses, one pulse each
        wr(0, 32'h8000_0000);
        send(a0, 0, "R8 back-to-back first");
        send(a255, 0, "R8 back-to-back second");
        idle(6);
        check(exp_hit.size() == 0, "R8 all verdicts arrived", exp_hit.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule